// File: doc/BRIEF.md
# Lock Qualifier and Stall Supervisor

This block sits beside the speed loop of a brushless spindle drive. It takes the loop's raw "phase locked" flag and produces a qualified, active-low lock output. The lock is reported only once the raw flag has stayed high for a programmable number of clock cycles, so that the brief lock pulses seen while the loop hunts during pull-in are hidden. A mask-enable input bypasses this qualification. Any loss of lock releases the output on the next edge and restarts the qualification count.

The same block watches for a stalled rotor. While the drive is running and the loop stays unlocked for a programmable number of consecutive cycles, it latches a fault that the drive stage uses to turn off the low-side switches. Only a stop request or a full reset clears that fault. The stall count pauses while the drive is slowing down after a speed change, and it restarts each time lock is reached. The block also holds the rest of the logic in an internal reset for a fixed number of cycles after the external reset is released. It also watches the reference clock. If no rising reference edge arrives within a timeout, the raw lock flag is ignored and the stall count runs even during deceleration. Starting without a reference clock therefore ends in a fault.

Top module: `motor_lock_supervisor`

## Requirements
- R1: After `rst` is released, `int_rst` stays 1 for exactly POR_CYCLES rising clock edges and then stays 0 until the next `rst`. While `int_rst` is 1, `lock_n` is 1 and `stall_fault` is 0.
- R2: With `mask_en`=1 and `run_req`=1, `lock_n` goes to 0 on the MASK_CYCLES-th consecutive edge at which the effective lock (`lock_raw`=1 with the reference clock present) is sampled high. It then stays 0 while that lock persists.
- R3: An edge that samples the effective lock low, or `run_req` low, sets `lock_n` to 1 and restarts the qualification count. Lock pulses shorter than MASK_CYCLES edges never drive `lock_n` to 0.
- R4: With `mask_en`=0 and `run_req`=1, `lock_n` is the inverse of the effective lock sampled one edge earlier.
- R5: An edge that samples `run_req`=0 sets `lock_n` to 1 and `stall_fault` to 0.
- R6: With `run_req`=1, `stall_fault` goes to 1 on the STALL_CYCLES-th consecutive counting edge. A counting edge is one that samples the effective lock low and `decel_active` low.
- R7: An edge that samples the effective lock high resets the stall count to zero.
- R8: Edges that sample `decel_active`=1 while the reference clock is present neither advance nor reset the stall count.
- R9: Once set, `stall_fault` stays 1 while `run_req`=1, whatever `lock_raw` and `decel_active` do.
- R10: The reference clock counts as missing once REF_TIMEOUT cycles pass with no synchronized rising edge of `ref_clk`. While it is missing, `lock_raw` is treated as 0 and `decel_active` does not pause the stall count. A new reference edge ends the missing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| lock_raw | input | 1 | Raw phase-lock flag from the speed loop, 1 = locked |
| run_req | input | 1 | 1 = run (start state), 0 = stop |
| decel_active | input | 1 | 1 while the drive decelerates after a speed change |
| ref_clk | input | 1 | Reference clock, asynchronous to `clk` |
| mask_en | input | 1 | 1 = qualify lock over MASK_CYCLES, 0 = pass through |
| lock_n | output | 1 | Qualified lock, 0 = locked |
| stall_fault | output | 1 | Latched stall fault, 1 = low-side drive off |
| int_rst | output | 1 | Internal reset pulse after power-up |

## Verification
The bench builds the block with POR_CYCLES=8, MASK_CYCLES=20, STALL_CYCLES=60 and REF_TIMEOUT=16, in place of the default values in the millions. These short limits let it reach, within a few thousand cycles, the exact edge on which lock is reported and the edge on which the stall fault trips. They also make room for split and paused stall windows one cycle either side of the limit, and for a reference clock that stops while the drive decelerates. A reference clock toggling every three cycles keeps the 16-cycle timeout quiet until the generator is switched off.

// File: rtl/mls_pkg.sv
package mls_pkg;

  // Bits needed for a counter holding the values 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_bits(input longint unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/mls_por_gen.sv
module mls_por_gen
  import mls_pkg::*;
#(
  parameter int unsigned POR_CYCLES = 125_000
) (
  input  logic clk,
  input  logic rst,
  output logic hold_o
);
  localparam int unsigned PW = cnt_bits(POR_CYCLES);
  localparam logic [PW-1:0] P_LAST = PW'(POR_CYCLES - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_o <= 1'b1;
    end else if (hold_o) begin
      if (cnt_q == P_LAST) hold_o <= 1'b0;
      else                 cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_POR_NO_REARM: assert property (@(posedge clk) disable iff (rst)
    !hold_o |=> !hold_o); // R1

endmodule

// File: rtl/mls_ref_watch.sv
module mls_ref_watch
  import mls_pkg::*;
#(
  parameter int unsigned REF_TIMEOUT = 2_500_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clr_i,
  input  logic ref_clk_i,
  output logic ref_lost_o
);
  localparam int unsigned RW = cnt_bits(REF_TIMEOUT + 1);
  localparam logic [RW-1:0] R_LIMIT = RW'(REF_TIMEOUT);

  logic [SYNC_STAGES:0] sync_q;
  logic [RW-1:0]        gap_q;
  logic                 rise;

  always_ff @(posedge clk) begin
    if (clr_i) sync_q <= '0;
    else       sync_q <= {sync_q[SYNC_STAGES-1:0], ref_clk_i};
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (clr_i)                gap_q <= '0;
    else if (rise)            gap_q <= '0;
    else if (gap_q != R_LIMIT) gap_q <= gap_q + 1'b1;
  end

  assign ref_lost_o = (gap_q == R_LIMIT);

  AST_REF_EDGE_REVIVES: assert property (@(posedge clk) disable iff (clr_i)
    rise |=> !ref_lost_o); // R10
  AST_REF_LOST_STICKS: assert property (@(posedge clk) disable iff (clr_i)
    (ref_lost_o && !rise) |=> ref_lost_o); // R10

endmodule

// File: rtl/mls_lock_mask.sv
module mls_lock_mask
  import mls_pkg::*;
#(
  parameter int unsigned MASK_CYCLES = 11_250_000
) (
  input  logic clk,
  input  logic clr_i,
  input  logic run_i,
  input  logic lock_i,
  input  logic mask_en_i,
  output logic lock_n_o
);
  localparam int unsigned MW = cnt_bits(MASK_CYCLES);
  localparam logic [MW-1:0] M_LAST = MW'(MASK_CYCLES - 1);

  logic [MW-1:0] qual_q;

  always_ff @(posedge clk) begin
    if (clr_i || !run_i || !lock_i) begin
      qual_q   <= '0;
      lock_n_o <= 1'b1;
    end else if (!mask_en_i) begin
      lock_n_o <= 1'b0;
    end else if (qual_q == M_LAST) begin
      lock_n_o <= 1'b0;
    end else begin
      qual_q <= qual_q + 1'b1;
    end
  end

  AST_DROP_RELEASES: assert property (@(posedge clk) disable iff (clr_i)
    (!lock_i || !run_i) |=> lock_n_o); // R3
  AST_ASSERT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (clr_i)
    $fell(lock_n_o) |-> $past(lock_i && run_i)); // R2

endmodule

// File: rtl/mls_stall_guard.sv
module mls_stall_guard
  import mls_pkg::*;
#(
  parameter int unsigned STALL_CYCLES = 1_000_000_000
) (
  input  logic clk,
  input  logic clr_i,
  input  logic run_i,
  input  logic lock_i,
  input  logic decel_i,
  input  logic ref_lost_i,
  output logic fault_o
);
  localparam int unsigned SW = cnt_bits(STALL_CYCLES);
  localparam logic [SW-1:0] S_LAST = SW'(STALL_CYCLES - 1);

  logic [SW-1:0] stall_q;
  logic          paused;

  // Deceleration pauses the count only while the reference clock is present.
  assign paused = decel_i & ~ref_lost_i;

  always_ff @(posedge clk) begin
    if (clr_i || !run_i) begin
      stall_q <= '0;
      fault_o <= 1'b0;
    end else if (fault_o) begin
      stall_q <= stall_q;
    end else if (lock_i) begin
      stall_q <= '0;
    end else if (paused) begin
      stall_q <= stall_q;
    end else if (stall_q == S_LAST) begin
      fault_o <= 1'b1;
    end else begin
      stall_q <= stall_q + 1'b1;
    end
  end

  AST_FAULT_LATCHED: assert property (@(posedge clk) disable iff (clr_i)
    (fault_o && run_i) |=> fault_o); // R9
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (clr_i)
    !run_i |=> !fault_o); // R5
  AST_TRIP_UNLOCKED: assert property (@(posedge clk) disable iff (clr_i)
    $rose(fault_o) |-> $past(!lock_i && run_i)); // R6

endmodule

// File: rtl/motor_lock_supervisor.sv
module motor_lock_supervisor #(
  parameter int unsigned POR_CYCLES   = 125_000,
  parameter int unsigned MASK_CYCLES  = 11_250_000,
  parameter int unsigned STALL_CYCLES = 1_000_000_000,
  parameter int unsigned REF_TIMEOUT  = 2_500_000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_raw,
  input  logic run_req,
  input  logic decel_active,
  input  logic ref_clk,
  input  logic mask_en,
  output logic lock_n,
  output logic stall_fault,
  output logic int_rst
);
  logic blk_clr;
  logic ref_lost;
  logic lock_eff;

  mls_por_gen #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk    (clk),
    .rst    (rst),
    .hold_o (int_rst)
  );

  assign blk_clr = rst | int_rst;

  mls_ref_watch #(.REF_TIMEOUT(REF_TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_ref (
    .clk        (clk),
    .clr_i      (blk_clr),
    .ref_clk_i  (ref_clk),
    .ref_lost_o (ref_lost)
  );

  assign lock_eff = lock_raw & ~ref_lost;

  mls_lock_mask #(.MASK_CYCLES(MASK_CYCLES)) u_mask (
    .clk       (clk),
    .clr_i     (blk_clr),
    .run_i     (run_req),
    .lock_i    (lock_eff),
    .mask_en_i (mask_en),
    .lock_n_o  (lock_n)
  );

  mls_stall_guard #(.STALL_CYCLES(STALL_CYCLES)) u_stall (
    .clk        (clk),
    .clr_i      (blk_clr),
    .run_i      (run_req),
    .lock_i     (lock_eff),
    .decel_i    (decel_active),
    .ref_lost_i (ref_lost),
    .fault_o    (stall_fault)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    int_rst |-> (lock_n && !stall_fault)); // R1

endmodule

// File: tb/motor_lock_supervisor_bench.sv
module motor_lock_supervisor_bench;
  localparam int POR   = 8;
  localparam int MASK  = 20;
  localparam int STALL = 60;
  localparam int TO    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock_raw = 1'b0, run_req = 1'b0, decel_active = 1'b0, mask_en = 1'b1;
  logic ref_clk = 1'b0;
  logic ref_en = 1'b1;
  logic lock_n, stall_fault, int_rst;

  always #4 clk = ~clk;

  motor_lock_supervisor #(
    .POR_CYCLES(POR), .MASK_CYCLES(MASK), .STALL_CYCLES(STALL),
    .REF_TIMEOUT(TO), .SYNC_STAGES(2)
  ) u_motor_lock_supervisor (
    .clk(clk), .rst(rst), .lock_raw(lock_raw), .run_req(run_req),
    .decel_active(decel_active), .ref_clk(ref_clk), .mask_en(mask_en),
    .lock_n(lock_n), .stall_fault(stall_fault), .int_rst(int_rst)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  bit started = 0, done = 0;

  task automatic chk(string req, logic act, logic exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Reference clock: toggles every three cycles while enabled.
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (ref_en) begin
        ph++;
        if (ph == 3) begin ref_clk = ~ref_clk; ph = 0; end
      end
    end
  end

  // Behavioural reference model, updated on each rising edge.
  bit m_irst = 1, m_ln = 1, m_f = 0;
  int m_pc = 0, m_mc = 0, m_sc = 0, m_gap = 0;
  bit s1 = 0, s2 = 0, s3 = 0;
  bit t_blk, t_miss, t_rise, t_lk;

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      m_irst = 1; m_pc = 0; m_mc = 0; m_sc = 0; m_gap = 0;
      m_ln = 1; m_f = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      t_blk  = m_irst;
      t_miss = (m_gap == TO);
      t_rise = s2 && !s3;
      t_lk   = lock_raw && !t_miss;
      if (t_blk) begin
        m_gap = 0; s1 = 0; s2 = 0; s3 = 0;
      end else begin
        if (t_rise) m_gap = 0; else if (m_gap < TO) m_gap++;
        s3 = s2; s2 = s1; s1 = ref_clk;
      end
      if (t_blk || !run_req || !t_lk) begin m_mc = 0; m_ln = 1; end
      else if (!mask_en) m_ln = 0;
      else if (m_mc == MASK - 1) m_ln = 0;
      else m_mc++;
      if (t_blk || !run_req) begin m_sc = 0; m_f = 0; end
      else if (m_f) ;
      else if (t_lk) m_sc = 0;
      else if (decel_active && !t_miss) ;
      else if (m_sc == STALL - 1) m_f = 1;
      else m_sc++;
      if (m_irst) begin
        if (m_pc == POR - 1) m_irst = 0; else m_pc++;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1", int_rst, m_irst, "int_rst vs model");
      chk(cur_req, lock_n, m_ln, "lock_n vs model");
      chk(cur_req, stall_fault, m_f, "stall_fault vs model");
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int hi;
    step(5);
    chk("R1", int_rst, 1'b1, "int_rst during rst");
    chk("R1", lock_n, 1'b1, "lock_n during rst");
    chk("R1", stall_fault, 1'b0, "fault during rst");
    rst = 0;
    hi = 0;
    step(1);
    while (int_rst === 1'b1 && hi < 100) begin hi++; step(1); end
    chk("R1", (hi + 1 == POR), 1'b1, "int_rst length equals POR_CYCLES");

    // R2: qualified lock
    cur_req = "R2";
    run_req = 1; lock_raw = 1; mask_en = 1;
    step(MASK - 1);
    chk("R2", lock_n, 1'b1, "lock_n one edge before mask time");
    step(1);
    chk("R2", lock_n, 1'b0, "lock_n at mask time");
    step(10);
    chk("R2", lock_n, 1'b0, "lock_n held while locked");

    // R3: drop and short pulses
    cur_req = "R3";
    lock_raw = 0; step(1);
    chk("R3", lock_n, 1'b1, "lock_n after drop");
    for (int k = 0; k < 4; k++) begin
      lock_raw = 1; step(MASK - 3);
      lock_raw = 0; step(2);
      chk("R3", lock_n, 1'b1, "short pulse masked");
    end

    // R4: mask bypass
    cur_req = "R4";
    mask_en = 0;
    for (int k = 0; k < 6; k++) begin
      lock_raw = ~lock_raw; step(1);
      chk("R4", lock_n, ~lock_raw, "pass-through lock_n");
    end

    // R5: stop
    cur_req = "R5";
    lock_raw = 1; step(2);
    run_req = 0; step(1);
    chk("R5", lock_n, 1'b1, "lock_n when stopped");
    chk("R5", stall_fault, 1'b0, "fault when stopped");
    mask_en = 1;

    // R6: stall trip
    cur_req = "R6";
    run_req = 1; lock_raw = 0; decel_active = 0;
    step(STALL - 1);
    chk("R6", stall_fault, 1'b0, "no fault one edge early");
    step(1);
    chk("R6", stall_fault, 1'b1, "fault at stall time");

    // R7: lock restarts count
    cur_req = "R7";
    run_req = 0; step(2);
    run_req = 1; step(STALL - 10);
    lock_raw = 1; step(1);
    lock_raw = 0; step(STALL - 10);
    chk("R7", stall_fault, 1'b0, "lock restarted stall count");

    // R8: deceleration pauses count
    cur_req = "R8";
    run_req = 0; step(2);
    run_req = 1; step(STALL - 20);
    decel_active = 1; step(40);
    decel_active = 0; step(19);
    chk("R8", stall_fault, 1'b0, "paused count one edge short");
    step(1);
    chk("R8", stall_fault, 1'b1, "paused count resumes to trip");

    // R9: fault latched
    cur_req = "R9";
    lock_raw = 1; decel_active = 1; step(MASK + 10);
    chk("R9", stall_fault, 1'b1, "fault held through lock");
    run_req = 0; step(1);
    chk("R9", stall_fault, 1'b0, "stop clears fault");
    decel_active = 0;

    // R10: missing reference clock
    cur_req = "R10";
    run_req = 1; lock_raw = 1; step(MASK + 5);
    chk("R10", lock_n, 1'b0, "locked with reference present");
    ref_en = 0; decel_active = 1;
    step(STALL + TO + 10);
    chk("R10", lock_n, 1'b1, "lock ignored without reference");
    chk("R10", stall_fault, 1'b1, "fault without reference despite decel");
    ref_en = 1; run_req = 0; decel_active = 0;
    step(4);
    finish_run();
  end
endmodule